// File: doc/BRIEF.md
# Shadowed Multi-Channel Pattern Updater

This block holds a 16-bit multi-channel output pattern, for example a mask that decides which PWM channels are driven. Software writes the next pattern into a shadow register at any time. The active pattern changes only through a controlled transfer. The transfer can be requested directly by software. It can also run as a two-step update: an arming event makes the update pending, and the next rising edge of a selected PWM synchronisation line copies the shadow into the active pattern.

In hardware mode, the arming event is the chosen edge (rising or falling) of one of eight trigger lines. In software mode, it is a set strobe. A clear strobe withdraws a pending update. A separate strobe zeroes the pattern. Every completed transfer raises a sticky done flag, which has its own set, clear and enable controls. A suspend request stops the block under one of four policies: ignore the request, freeze the pattern, force the pattern to zero, or run on until the next sync edge and zero the pattern at that edge.

Top module: `mc_pattern_updater`

## Requirements
- R1: After reset, `pattern` is 0, `updPending` is 0 and `doneFlag` is 0.
- R2: `shadowWrEn` loads `shadowWrData` into the shadow register. `swXferReq` copies the shadow into `pattern` at the next clock edge and sets `doneFlag`.
- R3: With `swMode`=0, an edge of trigger line `trigIn[trigSel]` sets `updPending` at the next clock edge. The edge is rising when `trigFall`=0 and falling when `trigFall`=1. Edges on lines that are not selected do nothing.
- R4: With `swMode`=1, `updEnSet` arms the update and trigger edges are ignored. With `swMode`=0, `updEnSet` is ignored.
- R5: `updEnClr` clears `updPending` at the next clock edge. It wins over an arming event in the same cycle.
- R6: While an update is pending, the first rising edge of `syncIn[syncSel]` copies the shadow into `pattern`, clears `updPending` and sets `doneFlag`, all at the same clock edge. Sync edges on lines that are not selected do nothing.
- R7: `patClrReq` sets `pattern` to 0 at the next clock edge. It wins over a transfer in the same cycle: that transfer is dropped and does not set `doneFlag`.
- R8: `doneFlag` is set by a transfer or by `doneSet`, and cleared by `doneClr`. A set wins over a clear. `doneIrq` equals `doneFlag` AND `doneEn`.
- R9: With `suspMode`=0, `suspReq` has no effect.
- R10: With `suspMode`=1 and `suspReq`=1, the block is frozen. `pattern` holds. Nothing arms. No sync transfer, software transfer or pattern clear takes place. A pending update is kept. `updEnClr` still clears it.
- R11: With `suspMode`=2 and `suspReq`=1, `pattern` is forced to 0 from the next clock edge on. Apart from that, the block is frozen as in R10.
- R12: With `suspMode`=3 and `suspReq`=1, the block runs normally until the first rising edge of the selected sync line. At that edge, `pattern` becomes 0 and any pending update is kept but not applied. The block then stays frozen as in R10 until `suspReq` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| shadowWrEn | input | 1 | Shadow pattern write strobe |
| shadowWrData | input | 16 | Shadow pattern write data |
| swMode | input | 1 | 1: update armed by software; 0: armed by trigger edge |
| updEnSet | input | 1 | Software arm strobe |
| updEnClr | input | 1 | Pending-update clear strobe |
| swXferReq | input | 1 | Immediate shadow transfer request |
| patClrReq | input | 1 | Pattern clear strobe |
| trigIn | input | 8 | Update trigger lines |
| trigSel | input | 3 | Trigger line index |
| trigFall | input | 1 | 1: falling trigger edge; 0: rising |
| syncIn | input | 4 | PWM sync lines |
| syncSel | input | 2 | Sync line index |
| suspReq | input | 1 | Suspend request (level) |
| suspMode | input | 2 | Suspend policy 0..3 (see R9 to R12) |
| doneEn | input | 1 | Done interrupt enable |
| doneSet | input | 1 | Done flag set strobe |
| doneClr | input | 1 | Done flag clear strobe |
| pattern | output | 16 | Active multi-channel pattern |
| updPending | output | 1 | Update armed and waiting for sync |
| doneFlag | output | 1 | Sticky transfer-done flag |
| doneIrq | output | 1 | Done flag gated by enable |

## Verification
The embedded assertions check on every cycle that a clear strobe or an applied sync edge empties the pending state, and that every transfer raises the done flag. They also check that a frozen block never arms, that suspend zeroing and pattern clearing leave the pattern at zero, and that the pattern holds whenever no strobe is issued. Only the bench scenarios can show the rest: correct line selection and edge polarity, the arming mode, the priority of clear over transfer, and the full suspend sequences, in particular the mode that waits for a sync edge, keeps the pending update and resumes after release.

// File: rtl/mcp_pkg.sv
package mcp_pkg;

  typedef struct packed {
    logic xfer;    // copy shadow into active pattern
    logic clrPat;  // software pattern clear
    logic rstPat;  // suspend-driven pattern reset
  } patStrobeT;

  typedef enum logic [1:0] {
    SUSP_IGNORE  = 2'd0,
    SUSP_HOLD    = 2'd1,
    SUSP_ZERO    = 2'd2,
    SUSP_AT_SYNC = 2'd3
  } suspModeT;

endpackage

// File: rtl/mcp_edge_pick.sv
module mcp_edge_pick #(
  parameter int N     = 8,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [N-1:0]     lines,
  input  logic [SEL_W-1:0] sel,
  input  logic             fallEdge,
  output logic             hit
);

  logic [N-1:0] prevLines;
  logic         curBit;
  logic         oldBit;

  // every line keeps its own history so a selector change makes no false edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevLines <= '0;
    else       prevLines <= lines;
  end

  always_comb begin
    curBit = lines[sel];
    oldBit = prevLines[sel];
    hit    = fallEdge ? (oldBit & ~curBit) : (curBit & ~oldBit);
  end

endmodule

// File: rtl/mcp_ctrl.sv
module mcp_ctrl
  import mcp_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      trigHit,
  input  logic      syncHit,
  input  logic      swMode,
  input  logic      updEnSet,
  input  logic      updEnClr,
  input  logic      swXferReq,
  input  logic      patClrReq,
  input  logic      suspReq,
  input  logic [1:0] suspMode,
  input  logic      doneEn,
  input  logic      doneSet,
  input  logic      doneClr,
  output patStrobeT strobe,
  output logic      updPending,
  output logic      doneFlag,
  output logic      doneIrq
);

  suspModeT smode;
  logic suspLatched;
  logic halt;
  logic suspSyncHit;
  logic arm;
  logic apply;
  logic swGo;

  always_comb begin
    smode       = suspModeT'(suspMode);
    halt        = suspReq & ((smode == SUSP_HOLD) | (smode == SUSP_ZERO) |
                             ((smode == SUSP_AT_SYNC) & suspLatched));
    suspSyncHit = suspReq & (smode == SUSP_AT_SYNC) & ~suspLatched & syncHit;
    arm         = ~halt & (swMode ? updEnSet : trigHit);
    apply       = updPending & syncHit & ~halt & ~suspSyncHit;
    swGo        = swXferReq & ~halt;
    strobe.rstPat = (suspReq & (smode == SUSP_ZERO)) | suspSyncHit;
    strobe.clrPat = patClrReq & ~halt & ~strobe.rstPat;
    strobe.xfer   = (apply | swGo) & ~strobe.clrPat & ~strobe.rstPat;
    doneIrq       = doneFlag & doneEn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      updPending  <= 1'b0;
      doneFlag    <= 1'b0;
      suspLatched <= 1'b0;
    end else begin
      if (apply || updEnClr) updPending <= 1'b0;
      else if (arm)          updPending <= 1'b1;

      if (strobe.xfer || doneSet) doneFlag <= 1'b1;
      else if (doneClr)           doneFlag <= 1'b0;

      if (!suspReq || smode != SUSP_AT_SYNC) suspLatched <= 1'b0;
      else if (syncHit)                      suspLatched <= 1'b1;
    end
  end

  assert_clr_pending_R5 : assert property (@(posedge clk) disable iff (!rstN)
    updEnClr |=> !updPending);

  assert_sync_consumes_R6 : assert property (@(posedge clk) disable iff (!rstN)
    (updPending && syncHit && !halt && !suspSyncHit) |=> !updPending);

  assert_xfer_sets_done_R8 : assert property (@(posedge clk) disable iff (!rstN)
    strobe.xfer |=> doneFlag);

  assert_frozen_no_arm_R10 : assert property (@(posedge clk) disable iff (!rstN)
    (halt && !updPending) |=> !updPending);

  assert_wait_keeps_pending_R12 : assert property (@(posedge clk) disable iff (!rstN)
    (suspSyncHit && updPending && !updEnClr) |=> updPending);

endmodule

// File: rtl/mcp_datapath.sv
module mcp_datapath
  import mcp_pkg::*;
#(
  parameter int PAT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             shadowWrEn,
  input  logic [PAT_W-1:0] shadowWrData,
  input  patStrobeT        strobe,
  output logic [PAT_W-1:0] patOut
);

  logic [PAT_W-1:0] shadowPat;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadowPat <= '0;
      patOut    <= '0;
    end else begin
      if (shadowWrEn) shadowPat <= shadowWrData;

      if (strobe.rstPat || strobe.clrPat) patOut <= '0;
      else if (strobe.xfer)               patOut <= shadowPat;
    end
  end

  assert_susp_zero_R11 : assert property (@(posedge clk) disable iff (!rstN)
    strobe.rstPat |=> (patOut == '0));

  assert_clear_zero_R7 : assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrPat |=> (patOut == '0));

  assert_hold_idle_R10 : assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.xfer || strobe.clrPat || strobe.rstPat) |=> $stable(patOut));

endmodule

// File: rtl/mc_pattern_updater.sv
module mc_pattern_updater
  import mcp_pkg::*;
#(
  parameter int PAT_W  = 16,
  parameter int TRIG_N = 8,
  parameter int SYNC_N = 4,
  localparam int TRIG_SEL_W = $clog2(TRIG_N),
  localparam int SYNC_SEL_W = $clog2(SYNC_N)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  shadowWrEn,
  input  logic [PAT_W-1:0]      shadowWrData,
  input  logic                  swMode,
  input  logic                  updEnSet,
  input  logic                  updEnClr,
  input  logic                  swXferReq,
  input  logic                  patClrReq,
  input  logic [TRIG_N-1:0]     trigIn,
  input  logic [TRIG_SEL_W-1:0] trigSel,
  input  logic                  trigFall,
  input  logic [SYNC_N-1:0]     syncIn,
  input  logic [SYNC_SEL_W-1:0] syncSel,
  input  logic                  suspReq,
  input  logic [1:0]            suspMode,
  input  logic                  doneEn,
  input  logic                  doneSet,
  input  logic                  doneClr,
  output logic [PAT_W-1:0]      pattern,
  output logic                  updPending,
  output logic                  doneFlag,
  output logic                  doneIrq
);

  logic      trigHit;
  logic      syncHit;
  patStrobeT strobe;

  mcp_edge_pick #(.N(TRIG_N), .SEL_W(TRIG_SEL_W)) u_trig (
    .clk(clk), .rstN(rstN), .lines(trigIn), .sel(trigSel),
    .fallEdge(trigFall), .hit(trigHit)
  );

  mcp_edge_pick #(.N(SYNC_N), .SEL_W(SYNC_SEL_W)) u_sync (
    .clk(clk), .rstN(rstN), .lines(syncIn), .sel(syncSel),
    .fallEdge(1'b0), .hit(syncHit)
  );

  mcp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .trigHit(trigHit), .syncHit(syncHit),
    .swMode(swMode), .updEnSet(updEnSet), .updEnClr(updEnClr),
    .swXferReq(swXferReq), .patClrReq(patClrReq), .suspReq(suspReq),
    .suspMode(suspMode), .doneEn(doneEn), .doneSet(doneSet), .doneClr(doneClr),
    .strobe(strobe), .updPending(updPending), .doneFlag(doneFlag), .doneIrq(doneIrq)
  );

  mcp_datapath #(.PAT_W(PAT_W)) u_dp (
    .clk(clk), .rstN(rstN), .shadowWrEn(shadowWrEn), .shadowWrData(shadowWrData),
    .strobe(strobe), .patOut(pattern)
  );

endmodule

// File: tb/mc_pattern_updater_tb.sv
module mc_pattern_updater_tb;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rstN;
  logic        shadowWrEn, swMode, updEnSet, updEnClr, swXferReq, patClrReq;
  logic [15:0] shadowWrData;
  logic [7:0]  trigIn;
  logic [2:0]  trigSel;
  logic        trigFall;
  logic [3:0]  syncIn;
  logic [1:0]  syncSel;
  logic        suspReq;
  logic [1:0]  suspMode;
  logic        doneEn, doneSet, doneClr;
  logic [15:0] pattern;
  logic        updPending, doneFlag, doneIrq;

  mc_pattern_updater u_dut (
    .clk(clk), .rstN(rstN), .shadowWrEn(shadowWrEn), .shadowWrData(shadowWrData),
    .swMode(swMode), .updEnSet(updEnSet), .updEnClr(updEnClr), .swXferReq(swXferReq),
    .patClrReq(patClrReq), .trigIn(trigIn), .trigSel(trigSel), .trigFall(trigFall),
    .syncIn(syncIn), .syncSel(syncSel), .suspReq(suspReq), .suspMode(suspMode),
    .doneEn(doneEn), .doneSet(doneSet), .doneClr(doneClr),
    .pattern(pattern), .updPending(updPending), .doneFlag(doneFlag), .doneIrq(doneIrq)
  );

  int    checks = 0;
  int    errors = 0;
  string tag = "R1";
  bit    finished = 0;

  // reference state, derived from the requirements
  logic [15:0] mPat = '0, mShadow = '0;
  logic        mPend = 0, mDone = 0, mLatch = 0;
  logic [7:0]  mTrigPrev = '0;
  logic [3:0]  mSyncPrev = '0;

  task automatic modelEdge();
    logic tRise, tFallE, tHit, sHit, frozen, zeroAtSync, zeroNow, moved;
    logic [15:0] nPat;
    logic nPend, nDone;
    tRise  = trigIn[trigSel] & ~mTrigPrev[trigSel];
    tFallE = ~trigIn[trigSel] & mTrigPrev[trigSel];
    tHit   = trigFall ? tFallE : tRise;
    sHit   = syncIn[syncSel] & ~mSyncPrev[syncSel];
    frozen = suspReq && ((suspMode == 2'd1) || (suspMode == 2'd2) ||
                         ((suspMode == 2'd3) && mLatch));
    zeroAtSync = suspReq && (suspMode == 2'd3) && !mLatch && sHit;
    zeroNow    = (suspReq && suspMode == 2'd2) || zeroAtSync;
    nPat = mPat; moved = 0;
    if (zeroNow) nPat = '0;
    else if (!frozen && patClrReq) nPat = '0;
    else if (!frozen && ((mPend && sHit) || swXferReq)) begin
      nPat = mShadow; moved = 1;
    end
    nPend = mPend;
    if (updEnClr) nPend = 0;
    else if (!frozen && !zeroAtSync && mPend && sHit) nPend = 0;
    else if (!frozen && (swMode ? updEnSet : tHit)) nPend = 1;
    nDone = (moved || doneSet) ? 1'b1 : (doneClr ? 1'b0 : mDone);
    @(posedge clk);
    mLatch = (suspReq && suspMode == 2'd3) ? (mLatch | sHit) : 1'b0;
    if (shadowWrEn) mShadow = shadowWrData;
    mPat = nPat; mPend = nPend; mDone = nDone;
    mTrigPrev = trigIn; mSyncPrev = syncIn;
  endtask

  task automatic step();
    modelEdge();
    #2;
    checks++;
    if (pattern !== mPat || updPending !== mPend || doneFlag !== mDone ||
        doneIrq !== (mDone & doneEn)) begin
      errors++;
      $display("FAIL %s: pattern=%h pend=%b done=%b irq=%b expected pattern=%h pend=%b done=%b irq=%b",
               tag, pattern, updPending, doneFlag, doneIrq, mPat, mPend, mDone, mDone & doneEn);
    end
    shadowWrEn = 0; updEnSet = 0; updEnClr = 0; swXferReq = 0; patClrReq = 0;
    doneSet = 0; doneClr = 0;
  endtask

  task automatic expectVal(string t, logic [15:0] pat, logic pend, logic done);
    checks++;
    if (pattern !== pat || updPending !== pend || doneFlag !== done) begin
      errors++;
      $display("FAIL %s: pattern=%h pend=%b done=%b expected pattern=%h pend=%b done=%b",
               t, pattern, updPending, doneFlag, pat, pend, done);
    end
  endtask

  task automatic writeShadow(logic [15:0] v);
    shadowWrEn = 1; shadowWrData = v; step();
  endtask

  task automatic syncPulse(int idx);
    syncIn[idx] = 1; step();
    syncIn[idx] = 0; step();
  endtask

  initial begin
    rstN = 0; shadowWrEn = 0; shadowWrData = 0; swMode = 0; updEnSet = 0; updEnClr = 0;
    swXferReq = 0; patClrReq = 0; trigIn = 0; trigSel = 0; trigFall = 0; syncIn = 0;
    syncSel = 0; suspReq = 0; suspMode = 0; doneEn = 0; doneSet = 0; doneClr = 0;
    repeat (3) @(posedge clk);
    #2;
    tag = "R1"; expectVal("R1 reset", 16'h0, 0, 0);
    @(negedge clk); rstN = 1;

    // R2 software transfer
    tag = "R2"; writeShadow(16'hA5A5);
    expectVal("R2 shadow write alone", 16'h0, 0, 0);
    swXferReq = 1; step();
    expectVal("R2 sw transfer", 16'hA5A5, 0, 1);

    // R8 done flag controls
    tag = "R8"; doneClr = 1; step();
    expectVal("R8 done clear", 16'hA5A5, 0, 0);
    doneSet = 1; doneClr = 1; doneEn = 1; step();
    expectVal("R8 set beats clear", 16'hA5A5, 0, 1);
    checks++;
    if (doneIrq !== 1'b1) begin errors++; $display("FAIL R8 irq=%b expected 1", doneIrq); end
    doneEn = 0; doneClr = 1; step();

    // R3 hardware trigger selection and polarity
    tag = "R3"; swMode = 0; trigSel = 3'd5; trigFall = 0; syncSel = 2'd2;
    writeShadow(16'h1234);
    trigIn[2] = 1; step();
    expectVal("R3 unselected trigger", 16'hA5A5, 0, 0);
    trigIn[5] = 1; step();
    expectVal("R3 rising edge arms", 16'hA5A5, 1, 0);

    // R6 sync selection and apply
    tag = "R6"; syncPulse(1);
    expectVal("R6 unselected sync", 16'hA5A5, 1, 0);
    syncIn[2] = 1; step();
    expectVal("R6 sync applies", 16'h1234, 0, 1);
    syncIn[2] = 0; step();
    syncPulse(2);
    expectVal("R6 sync without pending", 16'h1234, 0, 1);

    tag = "R3"; trigFall = 1; trigIn[5] = 0; step();
    expectVal("R3 falling edge arms", 16'h1234, 1, 1);

    // R5 clear and priority
    tag = "R5"; updEnClr = 1; step();
    expectVal("R5 clear pending", 16'h1234, 0, 1);
    trigIn[5] = 1; step();
    trigIn[5] = 0; updEnClr = 1; step();
    expectVal("R5 clear beats arm", 16'h1234, 0, 1);

    // R4 software arming
    tag = "R4"; swMode = 1; trigIn[5] = 1; step(); trigIn[5] = 0; step();
    expectVal("R4 trigger ignored in sw mode", 16'h1234, 0, 1);
    updEnSet = 1; step();
    expectVal("R4 sw arm", 16'h1234, 1, 1);
    updEnClr = 1; step();
    swMode = 0; updEnSet = 1; step();
    expectVal("R4 set ignored in hw mode", 16'h1234, 0, 1);

    // R7 clear wins over transfer
    tag = "R7"; doneClr = 1; writeShadow(16'h00FF);
    patClrReq = 1; swXferReq = 1; step();
    expectVal("R7 clear beats transfer", 16'h0, 0, 0);

    // R9 mode 0 ignored
    tag = "R9"; suspMode = 2'd0; suspReq = 1; swXferReq = 1; step();
    expectVal("R9 suspend ignored", 16'h00FF, 0, 1);
    suspReq = 0; step();

    // R10 freeze
    tag = "R10"; swMode = 1; writeShadow(16'hBEEF); updEnSet = 1; step();
    suspMode = 2'd1; suspReq = 1; step();
    syncPulse(2);
    swXferReq = 1; step();
    patClrReq = 1; step();
    updEnSet = 1; step();
    expectVal("R10 frozen", 16'h00FF, 1, 1);
    suspReq = 0; step();
    syncPulse(2);
    expectVal("R10 resumes", 16'hBEEF, 0, 1);

    // R11 forced zero
    tag = "R11"; suspMode = 2'd2; suspReq = 1; step();
    expectVal("R11 zeroed", 16'h0, 0, 1);
    swXferReq = 1; step();
    expectVal("R11 stays zero", 16'h0, 0, 1);
    suspReq = 0; swXferReq = 1; step();
    expectVal("R11 released", 16'hBEEF, 0, 1);

    // R12 suspend at sync
    tag = "R12"; writeShadow(16'h5A5A); updEnSet = 1; step();
    suspMode = 2'd3; suspReq = 1; step();
    expectVal("R12 still running", 16'hBEEF, 1, 1);
    syncIn[2] = 1; step();
    expectVal("R12 zero at sync", 16'h0, 1, 1);
    syncIn[2] = 0; step();
    syncPulse(2); swXferReq = 1; step();
    expectVal("R12 frozen after sync", 16'h0, 1, 1);
    suspReq = 0; step();
    syncPulse(2);
    expectVal("R12 resumes", 16'h5A5A, 0, 1);

    // constrained random mix
    tag = "R6 random";
    void'($urandom(32'h1C0FFEE));
    for (int i = 0; i < 4000; i++) begin
      shadowWrEn = ($urandom % 4) == 0; shadowWrData = 16'($urandom);
      updEnSet = ($urandom % 6) == 0; updEnClr = ($urandom % 12) == 0;
      swXferReq = ($urandom % 10) == 0; patClrReq = ($urandom % 20) == 0;
      doneSet = ($urandom % 15) == 0; doneClr = ($urandom % 8) == 0;
      if (($urandom % 10) == 0) doneEn = ~doneEn;
      trigIn = trigIn ^ (8'($urandom) & 8'($urandom));
      if (($urandom % 3) == 0) syncIn[syncSel] = ~syncIn[syncSel];
      if (($urandom % 50) == 0) trigSel = 3'($urandom);
      if (($urandom % 60) == 0) syncSel = 2'($urandom);
      if (($urandom % 40) == 0) swMode = ~swMode;
      if (($urandom % 40) == 0) trigFall = ~trigFall;
      if (($urandom % 25) == 0) suspReq = ~suspReq;
      if (($urandom % 30) == 0) suspMode = 2'($urandom);
      step();
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule